// File: doc/BRIEF.md
# Double-Buffered Pixel Hit Counter

This block is the counting slice of one detector pixel. It holds two independent saturating hit counters. Each rising edge of the discriminator hit, taken into the counter clock domain, adds one to whichever counter the fast select line names. The other counter stays frozen, so it can be copied into the parallel word that feeds the serial readout chain while the selected counter keeps accumulating. There is no dead time.

Flipping the select line between hits splits one acquisition into two event classes, for example prompt and delayed hits. A second fast line switches the pixel between counting and list operation at any time. In list operation, the synchronised hit level is passed on to the list-mode logic and no counter moves.

The counter depth is set at run time from 1 up to the full parameterised width. A counter that reaches its depth limit stays there instead of wrapping.

Top module: `pixel_dual_counter`

## Requirements
- R1: After reset both counters, `ro_word` and `list_hit` are zero.
- R2: With `mode_in`=1 (counting) and `gate_in`=1, each rising edge of `hit_in` adds exactly one to the counter chosen by `sel_in` (0 picks counter 0, 1 picks counter 1). A pulse held high for several cycles adds one.
- R3: A counter saturates at 2^N-1, where N is the effective depth, and holds that value when further hits arrive.
- R4: A hit arriving while `gate_in`=0 or `mode_in`=0 (list) changes neither counter.
- R5: A cycle with `ld_in`=1 copies the counter not selected by `sel_in` into `ro_word` at that clock edge. The selected counter keeps counting through that cycle.
- R6: `clr_in`=1 zeroes only the counter named by `clr_sel`; the other counter is untouched. A clear wins over an increment in the same cycle.
- R7: `list_hit` equals the synchronised hit level while `mode_in`=0 and `gate_in`=1, and is 0 otherwise.
- R8: Over a run of hits with the select toggled between them, the two counts sum to the number of hits injected, and each counter holds the hits made while it was selected.
- R9: The effective depth is `depth_cfg` clamped into 1..CNT_W: a value of 0 acts as 1, and a value above CNT_W acts as CNT_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hit_in | input | 1 | Asynchronous discriminator hit |
| sel_in | input | 1 | Selects the counter that accumulates |
| mode_in | input | 1 | 1 = counting, 0 = list |
| gate_in | input | 1 | Acquisition enable |
| depth_cfg | input | DEPTH_W (6) | Requested counter depth in bits |
| clr_in | input | 1 | Synchronous clear strobe |
| clr_sel | input | 1 | Counter targeted by the clear |
| ld_in | input | 1 | Load the idle counter into the readout word |
| ro_word | output | CNT_W (32) | Parallel word for the serial chain |
| list_hit | output | 1 | Synchronised hit routed to list-mode logic |

## Verification
The bench holds hit pulses for several cycles. A design that counted levels instead of edges would over-count there.

A clear is timed onto the exact cycle in which a count lands. A design that let the increment win would leave a one behind.

A load is issued while a hit is still being counted on the other counter. A design that stalled the active counter, or that copied the selected counter, would lose a hit or read the wrong value.

Saturation is driven past the limit at small depths, including a requested depth of zero. A design that wrapped would fall back to small counts. A design that skipped the clamp would saturate at zero or at the wrong limit.

A long run with the select toggling between hits exposes any hit that lands on the wrong counter or is lost at a select change.

// File: rtl/pdc_pkg.sv
package pdc_pkg;

  localparam logic MODE_LIST  = 1'b0;
  localparam logic MODE_COUNT = 1'b1;

  // Clamp a requested depth into 1..w
  function automatic int unsigned eff_depth(input int unsigned req, input int unsigned w);
    if (req == 0) return 1;
    if (req > w)  return w;
    return req;
  endfunction

endpackage

// File: rtl/pdc_hit_sync.sv
module pdc_hit_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hit_in,
  output logic hit_lvl,
  output logic hit_rise
);
  localparam int SHW = STAGES + 1;

  logic [SHW-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[SHW-2:0], hit_in};
  end

  assign hit_lvl  = sh_q[STAGES-1];
  assign hit_rise = sh_q[STAGES-1] & ~sh_q[STAGES];

  // an edge is a single-cycle event
  assert_single_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hit_rise |=> !hit_rise);

endmodule

// File: rtl/pdc_sat_counter.sv
module pdc_sat_counter
  import pdc_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int DEPTH_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [DEPTH_W-1:0] depth,
  input  logic               inc,
  input  logic               clr,
  output logic [CNT_W-1:0]   cnt_q
);
  logic [CNT_W-1:0] limit;
  logic             at_limit;

  function automatic logic [CNT_W-1:0] limit_of(input logic [DEPTH_W-1:0] d);
    int unsigned n;
    n = eff_depth(int'(d), CNT_W);
    return {CNT_W{1'b1}} >> (CNT_W - int'(n));
  endfunction

  always_comb begin
    limit    = limit_of(depth);
    at_limit = (cnt_q >= limit);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt_q <= '0;
    else if (clr)              cnt_q <= '0;
    else if (inc && !at_limit) cnt_q <= cnt_q + 1'b1;
  end

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (at_limit && !clr) |=> $stable(cnt_q));

  assert_step_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1));

  assert_clear_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));

endmodule

// File: rtl/pdc_readout_latch.sv
module pdc_readout_latch #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld,
  input  logic             sel,
  input  logic [CNT_W-1:0] cnt0,
  input  logic [CNT_W-1:0] cnt1,
  output logic [CNT_W-1:0] ro_word
);
  logic [CNT_W-1:0] idle_word;

  assign idle_word = sel ? cnt0 : cnt1;

  always_ff @(posedge clk) begin
    if (!rst_n)  ro_word <= '0;
    else if (ld) ro_word <= idle_word;
  end

  assert_load_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> (ro_word == (($past(sel)) ? $past(cnt0) : $past(cnt1))));

  assert_hold_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !ld |=> $stable(ro_word));

endmodule

// File: rtl/pixel_dual_counter.sv
module pixel_dual_counter
  import pdc_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int SYNC_STAGES = 2,
  parameter int DEPTH_W     = $clog2(CNT_W + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hit_in,
  input  logic               sel_in,
  input  logic               mode_in,
  input  logic               gate_in,
  input  logic [DEPTH_W-1:0] depth_cfg,
  input  logic               clr_in,
  input  logic               clr_sel,
  input  logic               ld_in,
  output logic [CNT_W-1:0]   ro_word,
  output logic               list_hit
);
  localparam int NCNT = 2;

  logic             hit_lvl;
  logic             hit_rise;
  logic             count_ev;
  logic [CNT_W-1:0] cnt [NCNT];

  pdc_hit_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .hit_in(hit_in),
    .hit_lvl(hit_lvl), .hit_rise(hit_rise)
  );

  assign count_ev = hit_rise && gate_in && (mode_in == MODE_COUNT);
  assign list_hit = hit_lvl && gate_in && (mode_in == MODE_LIST);

  for (genvar g = 0; g < NCNT; g++) begin : g_cnt
    logic inc_g;
    logic clr_g;
    assign inc_g = count_ev && (sel_in == g[0]);
    assign clr_g = clr_in && (clr_sel == g[0]);

    pdc_sat_counter #(.CNT_W(CNT_W), .DEPTH_W(DEPTH_W)) u_ctr (
      .clk(clk), .rst_n(rst_n), .depth(depth_cfg),
      .inc(inc_g), .clr(clr_g), .cnt_q(cnt[g])
    );

    // counter not selected stays frozen unless cleared
    assert_idle_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_in != g[0] && !clr_g) |=> $stable(cnt[g]));
  end

  pdc_readout_latch #(.CNT_W(CNT_W)) u_ro (
    .clk(clk), .rst_n(rst_n), .ld(ld_in), .sel(sel_in),
    .cnt0(cnt[0]), .cnt1(cnt[1]), .ro_word(ro_word)
  );

  assert_list_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_in == MODE_COUNT || !gate_in) |-> !list_hit);

  assert_no_count_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate_in || mode_in == MODE_LIST) && !clr_in |=> ($stable(cnt[0]) && $stable(cnt[1])));

endmodule

// File: tb/pixel_dual_counter_bench.sv
module pixel_dual_counter_bench;
  localparam int W  = 32;
  localparam int DW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hit_in = 1'b0, sel_in = 1'b0, mode_in = 1'b1, gate_in = 1'b1;
  logic [DW-1:0] depth_cfg = 6'd32;
  logic clr_in = 1'b0, clr_sel = 1'b0, ld_in = 1'b0;
  logic [W-1:0] ro_word;
  logic list_hit;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] got;
  logic done = 1'b0;

  always #5 clk = ~clk;

  pixel_dual_counter u_pixel_dual_counter (
    .clk(clk), .rst_n(rst_n), .hit_in(hit_in), .sel_in(sel_in),
    .mode_in(mode_in), .gate_in(gate_in), .depth_cfg(depth_cfg),
    .clr_in(clr_in), .clr_sel(clr_sel), .ld_in(ld_in),
    .ro_word(ro_word), .list_hit(list_hit)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_hit(input int len);
    @(negedge clk); hit_in = 1'b1;
    repeat (len) @(negedge clk);
    hit_in = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  // read a counter by selecting the other one and loading
  task automatic read_cnt(input logic which, output logic [W-1:0] val);
    logic keep;
    keep = sel_in;
    @(negedge clk); sel_in = ~which; ld_in = 1'b1;
    @(negedge clk); ld_in = 1'b0; val = ro_word; sel_in = keep;
  endtask

  task automatic clear_cnt(input logic which);
    @(negedge clk); clr_in = 1'b1; clr_sel = which;
    @(negedge clk); clr_in = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 ro_word", ro_word, '0);
    chk("R1 list_hit", {31'b0, list_hit}, '0);
    read_cnt(1'b0, got); chk("R1 cnt0", got, 0);
    read_cnt(1'b1, got); chk("R1 cnt1", got, 0);
  endtask

  task automatic t_edge_count;
    sel_in = 1'b0;
    pulse_hit(1); pulse_hit(6); pulse_hit(3);
    read_cnt(1'b0, got); chk("R2 multi-cycle pulses counted once", got, 3);
    read_cnt(1'b1, got); chk("R2 other counter untouched", got, 0);
  endtask

  task automatic t_gate_mode;
    gate_in = 1'b0; pulse_hit(2); gate_in = 1'b1;
    mode_in = 1'b0; pulse_hit(2); mode_in = 1'b1;
    read_cnt(1'b0, got); chk("R4 gate/list hits ignored cnt0", got, 3);
    read_cnt(1'b1, got); chk("R4 gate/list hits ignored cnt1", got, 0);
  endtask

  task automatic t_list;
    mode_in = 1'b0; gate_in = 1'b1;
    @(negedge clk); hit_in = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R7 list_hit follows hit", {31'b0, list_hit}, 1);
    gate_in = 1'b0; #1;
    chk("R7 list_hit gated off", {31'b0, list_hit}, 0);
    gate_in = 1'b1; mode_in = 1'b1; #1;
    chk("R7 list_hit quiet in counting", {31'b0, list_hit}, 0);
    mode_in = 1'b0;
    @(negedge clk); hit_in = 1'b0;
    repeat (4) @(negedge clk);
    chk("R7 list_hit drops", {31'b0, list_hit}, 0);
    mode_in = 1'b1;
  endtask

  task automatic t_clear;
    sel_in = 1'b1; pulse_hit(1); pulse_hit(1);
    clear_cnt(1'b0);
    read_cnt(1'b0, got); chk("R6 cleared counter zero", got, 0);
    read_cnt(1'b1, got); chk("R6 other counter kept", got, 2);
    // clear on the same edge as an increment
    sel_in = 1'b1;
    @(negedge clk); hit_in = 1'b1;
    @(negedge clk);
    @(negedge clk); clr_in = 1'b1; clr_sel = 1'b1;
    @(negedge clk); clr_in = 1'b0; hit_in = 1'b0;
    repeat (4) @(negedge clk);
    read_cnt(1'b1, got); chk("R6 clear beats increment", got, 0);
  endtask

  task automatic t_load_while_counting;
    sel_in = 1'b1; pulse_hit(1); pulse_hit(1); pulse_hit(1);
    sel_in = 1'b0;
    @(negedge clk); hit_in = 1'b1;
    @(negedge clk); ld_in = 1'b1;
    @(negedge clk); ld_in = 1'b0;
    chk("R5 idle counter loaded", ro_word, 3);
    hit_in = 1'b0;
    repeat (4) @(negedge clk);
    read_cnt(1'b0, got); chk("R5 active counter kept counting", got, 1);
    clear_cnt(1'b0); clear_cnt(1'b1);
  endtask

  task automatic t_saturate;
    depth_cfg = 6'd3; sel_in = 1'b0;
    for (int i = 0; i < 10; i++) pulse_hit(1);
    read_cnt(1'b0, got); chk("R3 saturate at 7", got, 7);
    depth_cfg = 6'd0; sel_in = 1'b1;
    for (int i = 0; i < 3; i++) pulse_hit(2);
    read_cnt(1'b1, got); chk("R9 depth 0 acts as 1", got, 1);
    clear_cnt(1'b1); depth_cfg = 6'd40;
    for (int i = 0; i < 9; i++) pulse_hit(1);
    read_cnt(1'b1, got); chk("R9 depth above width acts as full", got, 9);
    depth_cfg = 6'd32; clear_cnt(1'b0); clear_cnt(1'b1);
  endtask

  task automatic t_toggle_sum;
    logic [15:0] lfsr;
    int exp0, exp1;
    logic [W-1:0] g0, g1;
    lfsr = 16'hACE1; exp0 = 0; exp1 = 0;
    for (int i = 0; i < 60; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      sel_in = lfsr[0];
      if (lfsr[0]) exp1++; else exp0++;
      pulse_hit(1 + int'(lfsr[3:2]));
    end
    read_cnt(1'b0, g0); read_cnt(1'b1, g1);
    chk("R8 counter 0 share", g0, exp0);
    chk("R8 counter 1 share", g1, exp1);
    chk("R8 sum equals hits", g0 + g1, 60);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_edge_count();
    t_gate_mode();
    t_list();
    t_clear();
    t_load_while_counting();
    t_saturate();
    t_toggle_sum();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule